// File: doc/BRIEF.md
# Atomic Wide-Register Byte Bridge

This block lets an 8-bit register bus reach one register of 16, 24 or 32 bits so that every byte of it is read or written in a single clock edge. A set of shared byte-wide holding registers (one fewer than the number of bytes) sits between the bus and the wide register.

A write to a lower byte only parks the byte in a holding register. The write to the top byte then updates the whole register at once from the parked bytes. A read of byte zero returns the peripheral's live low byte and, on the same edge, freezes all higher live bytes into the holding registers. Later reads of the higher bytes return those frozen copies. Software can also read and write each holding register directly at its own address.

The address map has three parts. Addresses 0 to NB-1 are the register bytes, least significant first, where NB = DATA_W/8. Addresses NB to 2·NB-2 are holding registers 0 to NB-2. Every higher address is unmapped.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset, `reg_q` equals the `RESET_VAL` parameter, every holding register is zero, and `bus_rdata` is zero.
- R2: A write to byte address k with k < NB-1 stores the byte in holding register k. `reg_q` stays unchanged.
- R3: A write to byte address NB-1 loads `reg_q` at that edge with the write byte as the top byte. Below it, holding registers NB-2 down to 0 fill the lower bytes in order.
- R4: A read strobe at address 0 returns `reg_live[7:0]` on `bus_rdata` in the cycle after the strobe. At the same edge, live byte j+1 is copied into holding register j for every j.
- R5: A read of byte address k with 1 ≤ k ≤ NB-1 returns holding register k-1, not the current live value.
- R6: Addresses NB+j read and write holding register j directly. These accesses leave `reg_q` unchanged.
- R7: Reads and writes share the holding registers. A read of address 0 between staged lower-byte writes and the top-byte write replaces the staged bytes with the live snapshot. If a write and a snapshot hit the same holding register on one edge, the write wins.
- R8: `bus_rdata` changes only on an edge where the read strobe is high. Otherwise it holds its last value.
- R9: A write to an unmapped address has no effect. A read of an unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address on the register bus |
| bus_wdata | input | 8 | Write byte |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read byte, valid the cycle after the strobe |
| reg_q | output | DATA_W | Committed wide register value to the peripheral |
| reg_live | input | DATA_W | Live value of the peripheral's register |

## Verification
The assertions check the properties of a single edge on every cycle. They cover: a lower-byte write leaves `reg_q` alone, a top-byte write lands the written byte at the top, a byte-zero read returns the live low byte, `bus_rdata` is steady without a read strobe, and unmapped writes are inert. Some behaviour spans several accesses and only the bench scenarios show it. This includes the whole staged value arriving in one edge and reads returning the frozen snapshot after `reg_live` has moved. It also includes a snapshot read that clobbers staged write bytes, and direct access to the holding registers. The bench covers these with its reference model and with random traffic.

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata,
  output logic [DATA_W-1:0] reg_q,
  input  logic [DATA_W-1:0] reg_live
);
  localparam int NB = DATA_W / 8;
  localparam int NT = NB - 1;

  logic [31:0]     a;
  logic [NT*8-1:0] hold;
  logic [7:0]      rd_mux;

  assign a = 32'(bus_addr);

  wire wr_top = bus_we && (a == 32'(NB - 1));
  wire rd_low = bus_re && (a == 32'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0;
    end else begin
      for (int j = 0; j < NT; j++) begin
        if (bus_we && (a == 32'(j) || a == 32'(NB + j)))
          hold[8*j +: 8] <= bus_wdata;
        else if (rd_low)
          hold[8*j +: 8] <= reg_live[8*(j+1) +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      reg_q <= RESET_VAL;
    else if (wr_top)
      reg_q <= {bus_wdata, hold};
  end

  always_comb begin
    rd_mux = 8'h00;
    if (a == 32'd0) rd_mux = reg_live[7:0];
    for (int j = 0; j < NT; j++) begin
      if (a == 32'(j + 1) || a == 32'(NB + j))
        rd_mux = hold[8*j +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bus_rdata <= 8'h00;
    else if (bus_re)
      bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/wide_reg_bridge_chk.sv
module wide_reg_bridge_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [7:0]        bus_rdata,
  input logic [DATA_W-1:0] reg_q,
  input logic [DATA_W-1:0] reg_live
);
  localparam int NB = DATA_W / 8;
  logic [31:0] a;
  assign a = 32'(bus_addr);

  a_r2_low_write_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && a < 32'(NB - 1)) |=> reg_q == $past(reg_q));

  a_r3_top_byte_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && a == 32'(NB - 1)) |=> reg_q[DATA_W-1 -: 8] == $past(bus_wdata));

  a_r4_low_read_live: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && a == 32'd0) |=> bus_rdata == $past(reg_live[7:0]));

  a_r8_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> bus_rdata == $past(bus_rdata));

  a_r9_unmapped_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && a >= 32'(2*NB - 1)) |=> reg_q == $past(reg_q));

  a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && a >= 32'(2*NB - 1)) |=> bus_rdata == 8'h00);
endmodule

bind wide_reg_bridge wide_reg_bridge_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_wide_reg_bridge.sv
`timescale 1ns/1ps
module tb_wide_reg_bridge;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam logic [DW-1:0] RV = 32'h5A5A_0F0F;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic we = 0, re = 0;
  logic [7:0] rdata;
  logic [DW-1:0] q, live = '0;

  int checks = 0, fails = 0;
  logic [7:0] mt [3];
  logic [31:0] mq;
  logic [7:0] mr;

  always #10 clk = ~clk;

  wide_reg_bridge #(.DATA_W(DW), .ADDR_W(AW), .RESET_VAL(RV)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_re(re), .bus_rdata(rdata), .reg_q(q), .reg_live(live));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic [7:0] ot [3];
    int k;
    k = int'(addr);
    for (int j = 0; j < 3; j++) ot[j] = mt[j];
    if (re) begin
      if (k == 0) mr = live[7:0];
      else if (k <= 3) mr = ot[k-1];
      else if (k <= 6) mr = ot[k-4];
      else mr = 8'h00;
      if (k == 0) for (int j = 0; j < 3; j++) mt[j] = live[8*(j+1) +: 8];
    end
    if (we) begin
      if (k < 3) mt[k] = wdata;
      else if (k == 3) mq = {wdata, ot[2], ot[1], ot[0]};
      else if (k <= 6) mt[k-4] = wdata;
    end
  endtask

  task automatic step(string tag, logic w, logic r, int ad, logic [7:0] d);
    @(negedge clk);
    we = w; re = r; addr = AW'(ad); wdata = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({tag, " reg_q"}, q, mq);
    chk({tag, " rdata"}, {24'h0, rdata}, {24'h0, mr});
    we = 0; re = 0;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int j = 0; j < 3; j++) mt[j] = 8'h00;
    mq = RV; mr = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk("R1 reset reg_q", q, RV);
    chk("R1 reset rdata", {24'h0, rdata}, 32'h0);
    step("R1 hold0", 0, 1, 4, 0);
    chk("R1 hold0 zero", {24'h0, rdata}, 32'h0);

    step("R2 w0", 1, 0, 0, 8'h11);
    step("R2 w1", 1, 0, 1, 8'h22);
    step("R2 w2", 1, 0, 2, 8'h33);
    chk("R2 no commit", q, RV);
    step("R3 w3", 1, 0, 3, 8'h44);
    chk("R3 commit", q, 32'h4433_2211);

    live = 32'hA1B2_C3D4;
    step("R4 rd0", 0, 1, 0, 0);
    chk("R4 low live", {24'h0, rdata}, 32'hD4);
    live = 32'h0000_0000;
    step("R5 rd1", 0, 1, 1, 0);
    chk("R5 snap1", {24'h0, rdata}, 32'hC3);
    step("R5 rd2", 0, 1, 2, 0);
    chk("R5 snap2", {24'h0, rdata}, 32'hB2);
    step("R5 rd3", 0, 1, 3, 0);
    chk("R5 snap3", {24'h0, rdata}, 32'hA1);

    step("R6 wt1", 1, 0, 5, 8'h9C);
    chk("R6 no commit", q, 32'h4433_2211);
    step("R6 rt1", 0, 1, 5, 0);
    chk("R6 direct", {24'h0, rdata}, 32'h9C);
    step("R6 rd2 alias", 0, 1, 2, 0);
    chk("R6 alias", {24'h0, rdata}, 32'h9C);

    live = 32'h7766_5588;
    step("R7 w0", 1, 0, 0, 8'hE0);
    step("R7 w1", 1, 0, 1, 8'hE1);
    step("R7 rd0", 0, 1, 0, 0);
    step("R7 w2", 1, 0, 2, 8'hE2);
    step("R7 w3", 1, 0, 3, 8'hE3);
    chk("R7 clobbered", q, 32'hE3E2_6655);
    step("R7 both", 1, 1, 0, 8'h5F);
    step("R7 rt0", 0, 1, 4, 0);
    chk("R7 write wins", {24'h0, rdata}, 32'h5F);

    step("R8 idle", 0, 0, 0, 0);
    chk("R8 hold", {24'h0, rdata}, 32'h5F);
    step("R9 wun", 1, 0, 7, 8'hFF);
    chk("R9 no effect", q, 32'hE3E2_6655);
    step("R9 run", 0, 1, 7, 0);
    chk("R9 zero", {24'h0, rdata}, 32'h0);

    for (int i = 0; i < 400; i++) begin
      live = $urandom;
      step("R7 random", 1'($urandom), 1'($urandom), int'($urandom % 8), 8'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule